// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It brings the memory from power-on to a usable state. After reset it keeps the clock enable low and lets a stabilization window elapse with the clock running. It then raises the clock enable alongside a no-operation command. After that it issues a fixed series of commands, in this order:

- precharge of all banks
- a load of the extended mode register that turns the DLL on
- a load of the base mode register that also resets the DLL
- a second precharge of all banks
- two auto refreshes
- a final base-register load that leaves the DLL-reset bit clear

Between any two commands the block keeps a minimum spacing, and it fills every cycle that carries no command with a no-operation.

Every spacing is given as a time in nanoseconds and is converted to whole clock cycles at elaboration. The conversion uses a clock-period parameter and always rounds up. A separate lock counter starts when the DLL is reset. The done flag rises only when two conditions both hold: the final load's spacing has run out, and the lock wait has elapsed. The flag then stays high until the next reset. The remaining controller logic waits for the flag before it sends its first access.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and for STABLE cycles after it falls, the clock enable is low and the command lines carry NOP. Here STABLE is the stabilization time converted to cycles. The command lines are {select, row strobe, column strobe, write}, and NOP is 0111. While reset is high, init_done is low.
- R2: The clock enable rises on the STABLE-th rising edge after reset falls, together with a NOP. It stays high until the next reset.
- R3: The commands that follow appear in this fixed order:
  1. precharge-all
  2. extended-register load
  3. base-register load with DLL reset
  4. precharge-all
  5. auto refresh (code 0001, bank 0, address 0)
  6. auto refresh (code 0001, bank 0, address 0)
  7. base-register load for normal operation
- R4: A precharge-all is code 0010 with address bit 10 set, every other address bit zero, and bank 0.
- R5: The extended-register load is code 0000 with bank 01. Its address bit 0 is 0, which enables the DLL. Its address bit 1 holds the reduced-drive parameter. All other address bits are zero.
- R6: A base-register load is code 0000 with bank 00. Its address carries the burst-length code in bits 2:0, the interleave flag in bit 3 and the latency code in bits 6:4. Bit 8 is 1 for the DLL-reset load and 0 for the final load. Bits 7, 9, 10 and 11 are 0.
- R7: The spacing from one command to the next depends on the earlier command. It is 1 cycle after the clock-enable NOP, RP cycles after a precharge-all, MRD cycles after a register load, and RFC cycles after an auto refresh.
- R8: Each time parameter t becomes ceil(t / period) cycles, with a minimum of 1 cycle.
- R9: init_done rises on the rising edge that is the later of two points: MRD cycles after the final load, and DLL_LOCK_CYC cycles after the DLL-reset load. Once high, it stays high until reset.
- R10: No command other than NOP appears outside the listed sequence, including every cycle after init_done.
- R11: A reset asserted part-way through the sequence returns every output to its reset state, and the full sequence then restarts from the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_clk_en | output | 1 | Clock enable to the memory |
| mem_sel_n | output | 1 | Command bit 3: chip select, active low |
| mem_row_n | output | 1 | Command bit 2: row strobe, active low |
| mem_col_n | output | 1 | Command bit 1: column strobe, active low |
| mem_wr_n | output | 1 | Command bit 0: write enable, active low |
| mem_bank | output | 2 | Bank address / register select |
| mem_addr | output | 12 | Address bus / register op-code |
| init_done | output | 1 | High once initialization has completed |

## Verification
The bench builds the block with a 20000 ps period. None of its time parameters is a whole number of periods, so the rounding is visible: 3010 ns becomes 151 cycles, 30 ns becomes 2, 25 ns becomes 2 and 75 ns becomes 4. The DLL lock count keeps its value of 200. With these values the lock wait, not the last register spacing, sets the release point of init_done, and a whole run takes a few hundred cycles. The mode fields take non-default values (burst code 010, interleave on, latency code 110, reduced drive on), so every op-code bit position is checked. A second pass cuts the sequence short with a reset just after the extended-register load and then checks a complete restart.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned BANK_W = 2;

    // Command code as {select_n, row_n, col_n, write_n}
    typedef enum logic [3:0] {
        CMD_LOAD_REG = 4'b0000,
        CMD_REFRESH  = 4'b0001,
        CMD_PRECHG   = 4'b0010,
        CMD_IDLE     = 4'b0111
    } mem_cmd_e;

    // Last step issued; ST_POWER is the stabilization wait before any command
    typedef enum logic [3:0] {
        ST_POWER,
        ST_CKE_NOP,
        ST_PRE_A,
        ST_EXT_LOAD,
        ST_BASE_DLLRST,
        ST_PRE_B,
        ST_REF_A,
        ST_REF_B,
        ST_BASE_RUN,
        ST_DONE
    } init_step_e;

    typedef struct packed {
        mem_cmd_e          cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } cmd_word_t;

    localparam cmd_word_t IDLE_WORD = '{cmd: CMD_IDLE, bank: '0, addr: '0};

    localparam int unsigned ALL_BANKS_BIT = 10;
    localparam int unsigned DLL_RESET_BIT = 8;

    // Time in ns to whole cycles, rounded up, never below one
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ps);
        longint unsigned num;
        longint unsigned cyc;
        num = longint'(t_ns) * 64'd1000 + longint'(period_ps) - 64'd1;
        cyc = num / longint'(period_ps);
        if (cyc == 64'd0) cyc = 64'd1;
        return int'(cyc);
    endfunction

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic init_step_e step_after(input init_step_e s);
        case (s)
            ST_POWER:       return ST_CKE_NOP;
            ST_CKE_NOP:     return ST_PRE_A;
            ST_PRE_A:       return ST_EXT_LOAD;
            ST_EXT_LOAD:    return ST_BASE_DLLRST;
            ST_BASE_DLLRST: return ST_PRE_B;
            ST_PRE_B:       return ST_REF_A;
            ST_REF_A:       return ST_REF_B;
            ST_REF_B:       return ST_BASE_RUN;
            default:        return ST_DONE;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] base_opcode(input logic [2:0] burst,
                                                      input logic       interleave,
                                                      input logic [2:0] latency,
                                                      input logic       dll_reset);
        logic [ADDR_W-1:0] w;
        w                = '0;
        w[2:0]           = burst;
        w[3]             = interleave;
        w[6:4]           = latency;
        w[DLL_RESET_BIT] = dll_reset;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] ext_opcode(input logic reduced_drive);
        logic [ADDR_W-1:0] w;
        w    = '0;
        w[0] = 1'b0;            // DLL enabled
        w[1] = reduced_drive;
        return w;
    endfunction

endpackage

// File: rtl/ddr_init_steps.sv
module ddr_init_steps
    import ddr_init_pkg::*;
#(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned RP_CYC       = 1,
    parameter int unsigned MRD_CYC      = 1,
    parameter int unsigned RFC_CYC      = 1,
    parameter logic [2:0]  BURST_CODE   = 3'b011,
    parameter logic        INTERLEAVE   = 1'b0,
    parameter logic [2:0]  LATENCY_CODE = 3'b010,
    parameter logic        REDUCED_DRV  = 1'b0
) (
    input  init_step_e       sel,
    output cmd_word_t        word,
    output logic [CNT_W-1:0] gap
);

    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BANKS_BIT;

    always_comb begin
        word = IDLE_WORD;
        gap  = CNT_W'(1);
        case (sel)
            ST_CKE_NOP: begin
                word = IDLE_WORD;
                gap  = CNT_W'(1);
            end
            ST_PRE_A, ST_PRE_B: begin
                word.cmd  = CMD_PRECHG;
                word.addr = ALL_BANKS;
                gap       = CNT_W'(RP_CYC);
            end
            ST_EXT_LOAD: begin
                word.cmd  = CMD_LOAD_REG;
                word.bank = BANK_W'(1);
                word.addr = ext_opcode(REDUCED_DRV);
                gap       = CNT_W'(MRD_CYC);
            end
            ST_BASE_DLLRST: begin
                word.cmd  = CMD_LOAD_REG;
                word.addr = base_opcode(BURST_CODE, INTERLEAVE, LATENCY_CODE, 1'b1);
                gap       = CNT_W'(MRD_CYC);
            end
            ST_REF_A, ST_REF_B: begin
                word.cmd = CMD_REFRESH;
                gap      = CNT_W'(RFC_CYC);
            end
            ST_BASE_RUN: begin
                word.cmd  = CMD_LOAD_REG;
                word.addr = base_opcode(BURST_CODE, INTERLEAVE, LATENCY_CODE, 1'b0);
                gap       = CNT_W'(MRD_CYC);
            end
            default: begin
                word = IDLE_WORD;
                gap  = CNT_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned START_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cyc,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    // Loaded with gap-1 on the issuing edge: expires on edge issue+gap
    always_ff @(posedge clk) begin
        if (rst)
            remain <= CNT_W'(START_CYC - 1);
        else if (load)
            remain <= load_cyc - CNT_W'(1);
        else if (remain != '0)
            remain <= remain - CNT_W'(1);
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/ddr_init_dll_wait.sv
module ddr_init_dll_wait #(
    parameter int unsigned LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic locked
);

    localparam int unsigned W = $clog2(LOCK_CYC + 1);

    logic [W-1:0] left;
    logic         armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            left  <= W'(LOCK_CYC - 1);
        end else if (left != '0) begin
            left  <= left - W'(1);
        end
    end

    assign locked = armed && (left == '0);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS     = 7500,
    parameter int unsigned T_STABLE_NS       = 200000,
    parameter int unsigned T_RP_NS           = 20,
    parameter int unsigned T_MRD_NS          = 15,
    parameter int unsigned T_RFC_NS          = 80,
    parameter int unsigned DLL_LOCK_CYC      = 200,
    parameter logic [2:0]  MR_BURST_CODE     = 3'b011,
    parameter logic        MR_INTERLEAVE     = 1'b0,
    parameter logic [2:0]  MR_LATENCY_CODE   = 3'b010,
    parameter logic        EMR_REDUCED_DRIVE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    output logic        mem_clk_en,
    output logic        mem_sel_n,
    output logic        mem_row_n,
    output logic        mem_col_n,
    output logic        mem_wr_n,
    output logic [1:0]  mem_bank,
    output logic [11:0] mem_addr,
    output logic        init_done
);

    localparam int unsigned STABLE_CYC = ns_to_cycles(T_STABLE_NS, CLK_PERIOD_PS);
    localparam int unsigned RP_CYC     = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int unsigned MRD_CYC    = ns_to_cycles(T_MRD_NS, CLK_PERIOD_PS);
    localparam int unsigned RFC_CYC    = ns_to_cycles(T_RFC_NS, CLK_PERIOD_PS);
    localparam int unsigned CNT_W      =
        $clog2(max_of4(STABLE_CYC, RP_CYC, MRD_CYC, RFC_CYC) + 1);

    init_step_e       step_q;
    init_step_e       step_nxt;
    cmd_word_t        word_nxt;
    cmd_word_t        word_q;
    logic [CNT_W-1:0] gap_nxt;
    logic             gap_expired;
    logic             dll_locked;
    logic             issue;
    logic             cke_q;
    logic             done_q;

    assign step_nxt = step_after(step_q);
    assign issue    = gap_expired && (step_q != ST_BASE_RUN) && (step_q != ST_DONE);

    ddr_init_steps #(
        .CNT_W       (CNT_W),
        .RP_CYC      (RP_CYC),
        .MRD_CYC     (MRD_CYC),
        .RFC_CYC     (RFC_CYC),
        .BURST_CODE  (MR_BURST_CODE),
        .INTERLEAVE  (MR_INTERLEAVE),
        .LATENCY_CODE(MR_LATENCY_CODE),
        .REDUCED_DRV (EMR_REDUCED_DRIVE)
    ) u_steps (
        .sel (step_nxt),
        .word(word_nxt),
        .gap (gap_nxt)
    );

    ddr_init_gap_timer #(
        .CNT_W    (CNT_W),
        .START_CYC(STABLE_CYC)
    ) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (issue),
        .load_cyc(gap_nxt),
        .expired (gap_expired)
    );

    ddr_init_dll_wait #(
        .LOCK_CYC(DLL_LOCK_CYC)
    ) u_dll (
        .clk   (clk),
        .rst   (rst),
        .arm   (issue && (step_nxt == ST_BASE_DLLRST)),
        .locked(dll_locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_POWER;
            word_q <= IDLE_WORD;
            cke_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            word_q <= IDLE_WORD;
            if (issue) begin
                word_q <= word_nxt;
                step_q <= step_nxt;
                if (step_nxt == ST_CKE_NOP)
                    cke_q <= 1'b1;
            end else if ((step_q == ST_BASE_RUN) && gap_expired && dll_locked) begin
                done_q <= 1'b1;
                step_q <= ST_DONE;
            end
        end
    end

    assign mem_clk_en = cke_q;
    assign mem_sel_n  = word_q.cmd[3];
    assign mem_row_n  = word_q.cmd[2];
    assign mem_col_n  = word_q.cmd[1];
    assign mem_wr_n   = word_q.cmd[0];
    assign mem_bank   = word_q.bank;
    assign mem_addr   = word_q.addr;
    assign init_done  = done_q;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_clk_en,
    input logic        mem_sel_n,
    input logic        mem_row_n,
    input logic        mem_col_n,
    input logic        mem_wr_n,
    input logic [1:0]  mem_bank,
    input logic [11:0] mem_addr,
    input logic        init_done
);

    logic [3:0] code;
    assign code = {mem_sel_n, mem_row_n, mem_col_n, mem_wr_n};

    assert_idle_while_cke_low_R1: assert property (@(posedge clk) disable iff (rst)
        !mem_clk_en |-> (code == 4'b0111));

    assert_cke_stays_high_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mem_clk_en)) |-> mem_clk_en);

    assert_prechg_all_word_R4: assert property (@(posedge clk) disable iff (rst)
        (code == 4'b0010) |-> (mem_addr == 12'h400 && mem_bank == 2'b00));

    assert_load_select_R5: assert property (@(posedge clk) disable iff (rst)
        (code == 4'b0000) |-> (mem_bank == 2'b00 || mem_bank == 2'b01));

    assert_base_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (code == 4'b0000 && mem_bank == 2'b00) |-> (mem_addr[11:9] == 3'b000 && !mem_addr[7]));

    assert_done_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(init_done)) |-> init_done);

    assert_done_needs_cke_R9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> mem_clk_en);

    assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (code == 4'b0111));

endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_clk_en(mem_clk_en),
    .mem_sel_n (mem_sel_n),
    .mem_row_n (mem_row_n),
    .mem_col_n (mem_col_n),
    .mem_wr_n  (mem_wr_n),
    .mem_bank  (mem_bank),
    .mem_addr  (mem_addr),
    .init_done (init_done)
);

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;

    // Timing: 20000 ps period; 3010 ns -> 151, 30 ns -> 2, 25 ns -> 2, 75 ns -> 4 (R8)
    localparam int S_CYC = 151;
    localparam int P_CYC = 2;
    localparam int M_CYC = 2;
    localparam int F_CYC = 4;
    localparam int D_CYC = 200;

    localparam logic [2:0] BURST = 3'b010;
    localparam logic       INTLV = 1'b1;
    localparam logic [2:0] LAT   = 3'b110;
    localparam logic       RDRV  = 1'b1;

    localparam logic [3:0] C_IDLE = 4'b0111;
    localparam logic [3:0] C_PRE  = 4'b0010;
    localparam logic [3:0] C_LOAD = 4'b0000;
    localparam logic [3:0] C_REF  = 4'b0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_clk_en, mem_sel_n, mem_row_n, mem_col_n, mem_wr_n, init_done;
    logic [1:0]  mem_bank;
    logic [11:0] mem_addr;

    ddr_init_seq #(
        .CLK_PERIOD_PS    (20000),
        .T_STABLE_NS      (3010),
        .T_RP_NS          (30),
        .T_MRD_NS         (25),
        .T_RFC_NS         (75),
        .DLL_LOCK_CYC     (D_CYC),
        .MR_BURST_CODE    (BURST),
        .MR_INTERLEAVE    (INTLV),
        .MR_LATENCY_CODE  (LAT),
        .EMR_REDUCED_DRIVE(RDRV)
    ) i_ddr_init_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_clk_en(mem_clk_en),
        .mem_sel_n (mem_sel_n),
        .mem_row_n (mem_row_n),
        .mem_col_n (mem_col_n),
        .mem_wr_n  (mem_wr_n),
        .mem_bank  (mem_bank),
        .mem_addr  (mem_addr),
        .init_done (init_done)
    );

    always #10ns clk = ~clk;

    typedef struct {
        int         cyc;
        logic [3:0] cmd;
        logic [1:0] bank;
        logic [11:0] addr;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    int   exp_done = 0;
    int   cke_cyc  = -1;
    int   done_cyc = -1;
    bit   cke_drop = 0;
    bit   done_drop = 0;
    bit   finished = 0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [11:0] base_word(input logic dll);
        logic [11:0] w;
        w = 12'h000;
        w[2:0] = BURST;
        w[3]   = INTLV;
        w[6:4] = LAT;
        w[8]   = dll;
        return w;
    endfunction

    task automatic push(input int c, input logic [3:0] cmd, input logic [1:0] b,
                        input logic [11:0] a, input string tag);
        exp_t e;
        e.cyc = c; e.cmd = cmd; e.bank = b; e.addr = a; e.tag = tag;
        sb.push_back(e);
    endtask

    // Driver: expected command stream from R3..R7
    task automatic push_seq();
        int t;
        int t_dll;
        int t_last;
        sb.delete();
        t = S_CYC + 1;
        push(t, C_PRE, 2'b00, 12'h400, "R4");
        t += P_CYC;
        push(t, C_LOAD, 2'b01, {10'h000, RDRV, 1'b0}, "R5");
        t += M_CYC;
        t_dll = t;
        push(t, C_LOAD, 2'b00, base_word(1'b1), "R6");
        t += M_CYC;
        push(t, C_PRE, 2'b00, 12'h400, "R4");
        t += P_CYC;
        push(t, C_REF, 2'b00, 12'h000, "R3");
        t += F_CYC;
        push(t, C_REF, 2'b00, 12'h000, "R3");
        t += F_CYC;
        push(t, C_LOAD, 2'b00, base_word(1'b0), "R6");
        t_last = t;
        exp_done = (t_last + M_CYC > t_dll + D_CYC) ? t_last + M_CYC : t_dll + D_CYC;
    endtask

    task automatic clear_flags();
        cke_cyc = -1; done_cyc = -1; cke_drop = 0; done_drop = 0;
    endtask

    // Monitor: pops the scoreboard as commands appear
    always @(negedge clk) begin
        logic [3:0] code;
        code = {mem_sel_n, mem_row_n, mem_col_n, mem_wr_n};
        if (!rst && !finished) begin
            if (code != C_IDLE) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10", "command outside sequence", code, C_IDLE);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.cyc, "R7", "issue cycle", cyc, e.cyc);
                    chk({code, mem_bank, mem_addr} == {e.cmd, e.bank, e.addr}, e.tag,
                        "command word", {code, mem_bank, mem_addr}, {e.cmd, e.bank, e.addr});
                end
            end
            if (mem_clk_en && cke_cyc < 0) cke_cyc = cyc;
            if (!mem_clk_en && cke_cyc >= 0) cke_drop = 1;
            if (init_done && done_cyc < 0) done_cyc = cyc;
            if (!init_done && done_cyc >= 0) done_drop = 1;
        end
    end

    task automatic check_reset_state(input string req);
        chk(mem_clk_en == 1'b0, req, "clock enable in reset", mem_clk_en, 0);
        chk(init_done == 1'b0, req, "init_done in reset", init_done, 0);
        chk({mem_sel_n, mem_row_n, mem_col_n, mem_wr_n} == C_IDLE, req, "command in reset",
            {mem_sel_n, mem_row_n, mem_col_n, mem_wr_n}, C_IDLE);
    endtask

    task automatic check_full_run(input string rtag);
        chk(cke_cyc == S_CYC, "R1", {rtag, " clock enable rise cycle"}, cke_cyc, S_CYC);
        chk(cke_cyc == S_CYC, "R8", {rtag, " stable window rounded up"}, cke_cyc, S_CYC);
        chk(!cke_drop, "R2", {rtag, " clock enable held"}, cke_drop, 0);
        chk(done_cyc == exp_done, "R9", {rtag, " init_done rise cycle"}, done_cyc, exp_done);
        chk(!done_drop, "R9", {rtag, " init_done held"}, done_drop, 0);
        chk(sb.size() == 0, "R3", {rtag, " commands left unissued"}, sb.size(), 0);
        chk(init_done == 1'b1, "R10", {rtag, " still done after idle window"}, init_done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1ns;
        check_reset_state("R1");

        // Pass 1: full sequence
        clear_flags();
        push_seq();
        rst = 1'b0;
        repeat (exp_done + 40) @(negedge clk);
        #1ns;
        check_full_run("first pass");

        // Pass 2: reset part-way, after the extended-register load
        rst = 1'b1;
        repeat (2) @(negedge clk);
        clear_flags();
        push_seq();
        rst = 1'b0;
        repeat (S_CYC + 1 + P_CYC + 1) @(negedge clk);
        #1ns;
        chk(sb.size() == 5, "R11", "commands seen before abort", 7 - sb.size(), 2);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1ns;
        check_reset_state("R11");

        // Pass 3: restart from the stabilization wait
        clear_flags();
        push_seq();
        rst = 1'b0;
        repeat (exp_done + 40) @(negedge clk);
        #1ns;
        check_full_run("R11 restart");

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #4ms;
        if (!finished) begin
            chk(1'b0, "R3", "watchdog expired before sequence end", 0, 1);
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule